// File: doc/BRIEF.md
# Free-Running Timer with Comparator

This block is a memory-mapped timer peripheral. Its core is a 64-bit up-counter that advances by one on every clock while counting is enabled. A 64-bit comparator watches the counter. When comparison is enabled and the counter has reached or passed the comparator value, a sticky event flag sets. The flag drives an interrupt line whenever the interrupt enable is also set. An optional auto-increment mode adds a programmed step to the comparator on each match, which produces periodic events without software having to reprogram the comparator.

Software reaches every register over a plain 32-bit word bus. The bus has an address, write data, a write strobe, a read strobe and read data. Read data is combinational. It is valid in the same cycle as the read strobe and is zero while no read is active. The counter halves are read live and are not latched. A reader therefore takes the high word, then the low word, then the high word again, and repeats if the two high values differ. The comparator is reprogrammed with comparison disabled, and comparison is then re-enabled.

Top module: `free_run_timer`

## Requirements
- R1: After reset the counter, comparator, step value, control and flag are all zero, the counter does not advance, and `irq_out` is low.
- R2: While control bit 0 (count enable) is set the counter grows by exactly one per clock. While it is clear the counter holds its value.
- R3: Byte offset 0x00 writes and reads the counter's low word and offset 0x04 its high word. A bus write takes priority over counting. Reads are live, so a carry out of the low word is visible in the high word on the next read.
- R4: While control bit 1 (compare enable) is set, the event flag (bit 0 of the status word at offset 0x0C) sets in the cycle after the counter is greater than or equal to the comparator (offsets 0x10 low, 0x14 high). Strict excess counts as well as equality, and the flag stays set once set.
- R5: Writing status bit 0 as 1 clears the flag. Writing it as 0 leaves the flag unchanged.
- R6: While compare enable is clear the flag never sets, whatever values the comparator or the counter take.
- R7: While control bit 3 (auto-increment) and compare enable are set, each match adds the step register (offset 0x18) to the comparator.
- R8: `irq_out` is high exactly while the flag and control bit 2 (interrupt enable) are both set.
- R9: When a match and a write-1 clear of the flag fall in the same cycle, the flag stays set.
- R10: Control, comparator and step registers read back what was written. Reads of offset 0x1C, or of any address not aligned to a word, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the counting tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read strobe, gates the read data |
| bus_rdata | output | WORD_W | Read data, zero when no read is active |
| irq_out | output | 1 | Interrupt, flag AND interrupt enable |

## Verification
The hardest situation to reach is a clear of the flag that lands on the same edge as a live match. The stimulus arranges this by leaving the counter stopped above a comparator that is enabled. The match condition then holds on every edge, so any write-1 clear collides with it. The flag is expected to survive the clear, and it only drops once compare enable has been withdrawn. The carry between the counter halves is forced in a similar way. The counter is preset to two ticks below a wrap of the low word, and the counter is read live on both sides of the wrap.

// File: rtl/free_run_timer.sv
module free_run_timer #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int CNT_W = 2 * WORD_W;
  localparam int SEL_W = ADDR_W - 2;
  localparam logic [SEL_W-1:0] SEL_CNT_LO = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CNT_HI = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_STAT   = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_CMP_LO = SEL_W'(4);
  localparam logic [SEL_W-1:0] SEL_CMP_HI = SEL_W'(5);
  localparam logic [SEL_W-1:0] SEL_STEP   = SEL_W'(6);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [WORD_W-1:0] step_q;
  logic [3:0]        ctrl_q;
  logic              flag_q;

  logic [SEL_W-1:0]  sel;
  logic              aligned;
  logic              wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  logic              wr_ctrl, wr_stat, wr_step;
  logic              run, cmp_on, irq_on, auto_on;
  logic              hit, clr;

  assign sel     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign wr_cnt_lo = bus_we && aligned && (sel == SEL_CNT_LO);
  assign wr_cnt_hi = bus_we && aligned && (sel == SEL_CNT_HI);
  assign wr_ctrl   = bus_we && aligned && (sel == SEL_CTRL);
  assign wr_stat   = bus_we && aligned && (sel == SEL_STAT);
  assign wr_cmp_lo = bus_we && aligned && (sel == SEL_CMP_LO);
  assign wr_cmp_hi = bus_we && aligned && (sel == SEL_CMP_HI);
  assign wr_step   = bus_we && aligned && (sel == SEL_STEP);

  assign run     = ctrl_q[0];
  assign cmp_on  = ctrl_q[1];
  assign irq_on  = ctrl_q[2];
  assign auto_on = ctrl_q[3];

  assign hit = cmp_on && (cnt_q >= cmp_q);
  assign clr = wr_stat && bus_wdata[0];

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt_lo || wr_cnt_hi) begin
      if (wr_cnt_lo) cnt_d[WORD_W-1:0]     = bus_wdata;
      if (wr_cnt_hi) cnt_d[CNT_W-1:WORD_W] = bus_wdata;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    cmp_d = cmp_q;
    if (wr_cmp_lo || wr_cmp_hi) begin
      if (wr_cmp_lo) cmp_d[WORD_W-1:0]     = bus_wdata;
      if (wr_cmp_hi) cmp_d[CNT_W-1:WORD_W] = bus_wdata;
    end else if (hit && auto_on) begin
      cmp_d = cmp_q + {{WORD_W{1'b0}}, step_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      step_q <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      if (wr_step) step_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[3:0];
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re && aligned) begin
      case (sel)
        SEL_CNT_LO: bus_rdata = cnt_q[WORD_W-1:0];
        SEL_CNT_HI: bus_rdata = cnt_q[CNT_W-1:WORD_W];
        SEL_CTRL:   bus_rdata = {{(WORD_W-4){1'b0}}, ctrl_q};
        SEL_STAT:   bus_rdata = {{(WORD_W-1){1'b0}}, flag_q};
        SEL_CMP_LO: bus_rdata = cmp_q[WORD_W-1:0];
        SEL_CMP_HI: bus_rdata = cmp_q[CNT_W-1:WORD_W];
        SEL_STEP:   bus_rdata = step_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_out = flag_q && irq_on;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_q)); // R2
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_on && (cnt_q >= cmp_q)) |=> flag_q); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !(cmp_on && (cnt_q >= cmp_q))) |=> !flag_q); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_on && !flag_q) |=> !flag_q); // R6
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_on && !wr_cmp_lo && !wr_cmp_hi)
      |=> (cmp_q == $past(cmp_q) + {{WORD_W{1'b0}}, $past(step_q)})); // R7
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> !irq_out); // R8
  AST_CLASH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && hit) |=> flag_q); // R9
endmodule

// File: tb/free_run_timer_tb_top.sv
module free_run_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int fails = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  free_run_timer #(.WORD_W(32), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;
  // {req[3:0], op[1:0], addr[4:0], data_or_expected[31:0]}
  localparam int NVEC = 61;
  localparam logic [42:0] VEC [NVEC] = '{
    {4'd1,  OP_RD,   5'h08, 32'h0},          // R1 control zero
    {4'd1,  OP_RD,   5'h00, 32'h0},          // R1 counter zero
    {4'd1,  OP_RD,   5'h0C, 32'h0},          // R1 flag zero
    {4'd1,  OP_IDLE, 5'h00, 32'd3},
    {4'd1,  OP_RD,   5'h00, 32'h0},          // R1 counter stopped
    {4'd2,  OP_WR,   5'h08, 32'h1},
    {4'd2,  OP_IDLE, 5'h00, 32'd4},
    {4'd2,  OP_RD,   5'h00, 32'd4},          // R2 one per clock
    {4'd2,  OP_WR,   5'h08, 32'h0},
    {4'd2,  OP_RD,   5'h00, 32'd5},          // R2
    {4'd2,  OP_IDLE, 5'h00, 32'd3},
    {4'd2,  OP_RD,   5'h00, 32'd5},          // R2 holds when disabled
    {4'd3,  OP_WR,   5'h00, 32'hFFFF_FFFE},
    {4'd3,  OP_WR,   5'h04, 32'h5},
    {4'd3,  OP_RD,   5'h04, 32'h5},          // R3 high word preset
    {4'd3,  OP_RD,   5'h00, 32'hFFFF_FFFE},  // R3 low word preset
    {4'd3,  OP_WR,   5'h08, 32'h1},
    {4'd3,  OP_IDLE, 5'h00, 32'd2},
    {4'd3,  OP_RD,   5'h00, 32'h0},          // R3 low wrapped
    {4'd3,  OP_RD,   5'h04, 32'h6},          // R3 carry into high
    {4'd3,  OP_WR,   5'h08, 32'h0},
    {4'd3,  OP_RD,   5'h00, 32'h1},          // R3
    {4'd6,  OP_WR,   5'h00, 32'h0},
    {4'd6,  OP_WR,   5'h04, 32'h0},
    {4'd6,  OP_WR,   5'h10, 32'd10},
    {4'd6,  OP_WR,   5'h14, 32'h0},
    {4'd10, OP_RD,   5'h10, 32'd10},         // R10 comparator readback
    {4'd6,  OP_WR,   5'h08, 32'h1},
    {4'd6,  OP_IDLE, 5'h00, 32'd20},
    {4'd6,  OP_RD,   5'h0C, 32'h0},          // R6 passed comparator, compare off
    {4'd6,  OP_WR,   5'h08, 32'h0},
    {4'd2,  OP_RD,   5'h00, 32'd21},         // R2
    {4'd6,  OP_WR,   5'h10, 32'd3},
    {4'd6,  OP_RD,   5'h0C, 32'h0},          // R6 comparator write below counter
    {4'd4,  OP_WR,   5'h08, 32'h2},
    {4'd4,  OP_IDLE, 5'h00, 32'd1},
    {4'd4,  OP_RD,   5'h0C, 32'h1},          // R4 greater-than sets flag
    {4'd5,  OP_WR,   5'h0C, 32'h0},
    {4'd5,  OP_RD,   5'h0C, 32'h1},          // R5 write 0 ignored
    {4'd9,  OP_WR,   5'h0C, 32'h1},
    {4'd9,  OP_RD,   5'h0C, 32'h1},          // R9 match beats clear
    {4'd5,  OP_WR,   5'h08, 32'h0},
    {4'd5,  OP_WR,   5'h0C, 32'h1},
    {4'd5,  OP_RD,   5'h0C, 32'h0},          // R5 write 1 clears
    {4'd7,  OP_WR,   5'h10, 32'd30},
    {4'd7,  OP_WR,   5'h18, 32'd5},
    {4'd7,  OP_WR,   5'h08, 32'hB},
    {4'd7,  OP_IDLE, 5'h00, 32'd10},
    {4'd7,  OP_RD,   5'h10, 32'd35},         // R7 first step
    {4'd7,  OP_IDLE, 5'h00, 32'd5},
    {4'd7,  OP_RD,   5'h10, 32'd40},         // R7 second step
    {4'd7,  OP_WR,   5'h08, 32'h0},
    {4'd7,  OP_RD,   5'h0C, 32'h1},          // R7 flag raised
    {4'd7,  OP_RD,   5'h00, 32'd37},         // R7 counter position
    {4'd5,  OP_WR,   5'h0C, 32'h1},
    {4'd5,  OP_RD,   5'h0C, 32'h0},          // R5
    {4'd10, OP_RD,   5'h18, 32'd5},          // R10 step readback
    {4'd10, OP_RD,   5'h1C, 32'h0},          // R10 unmapped
    {4'd10, OP_WR,   5'h08, 32'hE},
    {4'd10, OP_RD,   5'h08, 32'hE},          // R10 control readback
    {4'd10, OP_WR,   5'h08, 32'h0}
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, {31'd0, irq_out}, 32'h0); // R1 irq low in reset
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][38:37])
        OP_WR: wr(VEC[i][36:32], VEC[i][31:0]);
        OP_RD: begin
          rd(VEC[i][36:32], rv);
          check(int'(VEC[i][42:39]), rv, VEC[i][31:0]);
        end
        default: repeat (int'(VEC[i][31:0])) @(negedge clk);
      endcase
    end

    rd(5'h11, rv);
    check(10, rv, 32'h0); // R10 misaligned read

    wr(5'h10, 32'h0);
    wr(5'h08, 32'h2);
    @(negedge clk);
    check(8, {31'd0, irq_out}, 32'h0); // R8 flag set, irq disabled
    rd(5'h0C, rv);
    check(4, rv, 32'h1);               // R4
    wr(5'h08, 32'h6);
    check(8, {31'd0, irq_out}, 32'h1); // R8 both set
    wr(5'h08, 32'h4);
    wr(5'h0C, 32'h1);
    check(8, {31'd0, irq_out}, 32'h0); // R8 flag cleared
    wr(5'h08, 32'h6);
    @(negedge clk);
    check(8, {31'd0, irq_out}, 32'h1); // R8 reasserted

    rst_n = 1'b0;
    @(negedge clk);
    check(1, {31'd0, irq_out}, 32'h0); // R1 reset drops irq
    rst_n = 1'b1;
    rd(5'h00, rv);
    check(1, rv, 32'h0);               // R1 counter cleared
    rd(5'h10, rv);
    check(1, rv, 32'h0);               // R1 comparator cleared
    rd(5'h18, rv);
    check(1, rv, 32'h0);               // R1 step cleared
    repeat (2) @(negedge clk);
    rd(5'h00, rv);
    check(1, rv, 32'h0);               // R1 counter stays stopped

    finish_run();
  end
endmodule